// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outbound frames from memory to a byte stream. Software builds a linked ring of four-word descriptors in memory. Each descriptor holds a parameter word, a link to the next descriptor, a pointer to a data buffer and a completion word. The engine fetches a descriptor, reads its buffer one 32-bit word at a time and sends the bytes on a valid/ready stream with start and end markers. It then writes a done flag into the completion word and follows the link.

Flow control uses the hold bit in the parameter word, not head and tail index registers. When the engine reads a descriptor whose hold bit is set, it parks. It then re-reads that parameter word at a programmed poll interval until software clears the bit. A restart command makes it re-read at once instead of waiting for the next poll.

Software uses three register addresses. Address 0 takes commands, address 1 holds the first-descriptor address, and address 2 holds the poll interval. A single raw interrupt pulse is the only event output.

Top module: `tdma_tx_dma`

## Requirements
- R1: After reset, tx_valid_o, mem_req_o, active_o and irq_o are all low. The poll interval is 7.
- R2: A write to register 0 with bit 0 set is the start command. While idle, start makes the engine read its first parameter word at the address held in register 1.
- R3: Bytes leave in little-endian order: byte k of a buffer is bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4. The byte count in bits 21:0 of the parameter word trims the final word. tx_data_o and the markers stay stable while tx_ready_i is low.
- R4: tx_sop_o is high only on the first byte of a descriptor, and only if bit 29 of the parameter word is set. tx_eop_o is high only on its last byte, and only if bit 30 is set.
- R5: After the last byte of a descriptor, the engine writes 32'h8000_0000 (done flag in bit 31) to the fourth word of that descriptor, at offset 12.
- R6: If bit 31 (hold) of the parameter word is set, the engine sends no data and stays active. It re-reads that parameter word with successive reads spaced between interval+1 and interval+4 cycles, where the interval is the value in register 2.
- R7: A write to register 0 with bit 1 set is the restart command. While parked, restart causes an immediate re-read of the current descriptor's parameter word.
- R8: After completing a descriptor, the engine fetches the descriptor at the address in its next-pointer word (offset 4). A link back to an earlier descriptor closes a ring.
- R9: A descriptor with a byte count of zero gets its done flag written. No buffer word is read and no byte is sent.
- R10: A write to register 0 with bit 2 set is the off command. It stops the channel after the current memory or stream beat. From then on active_o is low, and no further request, byte or done write occurs.
- R11: irq_o pulses for one cycle when a done write finishes, if bit 28 is set, or if bits 27 and 30 are both set. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 commands, 1 first descriptor, 2 poll interval |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_sop_o | output | 1 | First byte of a frame |
| tx_eop_o | output | 1 | Last byte of a frame |
| active_o | output | 1 | Channel is running or parked |
| irq_o | output | 1 | Raw completion event pulse |

## Verification
The bench memory acknowledges each request one cycle after it is raised. Each descriptor therefore takes six cycles to fetch and each buffer word two cycles. A parked descriptor is re-read every interval+3 cycles, so gaps are accepted between interval+1 and interval+4. A restart brings the parameter read within two cycles. The monitor compares every byte at its handshake edge against a queue filled when the frame was set up. Done words, read addresses, irq counts and the idle state after off are checked only after a settling window longer than the longest of these latencies.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned LANES = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARAM, ST_PARK, ST_NEXT, ST_BUF, ST_DATA, ST_SEND, ST_DONE
  } tdma_state_e;

  // parameter word bit positions
  localparam int unsigned P_HOLD = 31;
  localparam int unsigned P_EOP  = 30;
  localparam int unsigned P_SOP  = 29;
  localparam int unsigned P_ICPT = 28;
  localparam int unsigned P_IEOP = 27;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_FIRST = 2'd1;
  localparam logic [1:0] RA_POLL  = 2'd2;

  localparam int unsigned C_START   = 0;
  localparam int unsigned C_RESTART = 1;
  localparam int unsigned C_OFF     = 2;

  localparam logic [DW-1:0] DONE_WORD = 32'h8000_0000;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned PW       = 16,
  parameter int unsigned POLL_DEF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] first_o,
  output logic [PW-1:0] poll_o,
  output logic          start_o,
  output logic          restart_o,
  output logic          off_o
);
  logic ctrl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
      poll_o  <= PW'(POLL_DEF);
    end else if (we_i) begin
      if (addr_i == RA_FIRST) first_o <= wdata_i[AW-1:0];
      if (addr_i == RA_POLL)  poll_o  <= wdata_i[PW-1:0];
    end
  end

  assign ctrl_wr   = we_i && (addr_i == RA_CTRL);
  assign start_o   = ctrl_wr && wdata_i[C_START];
  assign restart_o = ctrl_wr && wdata_i[C_RESTART];
  assign off_o     = ctrl_wr && wdata_i[C_OFF];
endmodule

// File: rtl/tdma_poll_timer.sv
module tdma_poll_timer #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [PW-1:0] ival_i,
  output logic          expire_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= ival_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - PW'(1);
  end

  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tdma_byte_sel.sv
module tdma_byte_sel
  import tdma_pkg::*;
#(
  parameter int unsigned IW = $clog2(LANES)
) (
  input  logic [DW-1:0] word_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*8 +: 8];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/tdma_tx_dma.sv
module tdma_tx_dma
  import tdma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned CW       = 22,
  parameter int unsigned PW       = 16,
  parameter int unsigned POLL_DEF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  output logic          active_o,
  output logic          irq_o
);
  localparam int unsigned IW = $clog2(LANES);
  localparam logic [AW-1:0] OFS_NEXT = AW'(LANES);
  localparam logic [AW-1:0] OFS_BUF  = AW'(2 * LANES);
  localparam logic [AW-1:0] OFS_DONE = AW'(3 * LANES);
  localparam logic [AW-1:0] WMASK    = ~AW'(LANES - 1);

  tdma_state_e   state_q;
  logic [AW-1:0] first_addr, cur_q, nxt_q, ptr_q;
  logic [PW-1:0] poll_ival;
  logic          start_p, restart_p, off_p;
  logic [CW-1:0] cnt_q, rem_q;
  logic          f_eop_q, f_sop_q, f_icpt_q, f_ieop_q;
  logic [DW-1:0] word_q;
  logic [IW-1:0] idx_q;
  logic          first_q, stop_q, irq_q;
  logic          halt, park_load, poll_due, beat;

  tdma_regs #(.AW(AW), .PW(PW), .POLL_DEF(POLL_DEF)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .first_o(first_addr), .poll_o(poll_ival),
    .start_o(start_p), .restart_o(restart_p), .off_o(off_p)
  );

  assign halt      = stop_q || off_p;
  assign park_load = (state_q == ST_PARAM) && mem_ack_i && mem_rdata_i[P_HOLD] && !halt;

  tdma_poll_timer #(.PW(PW)) u_poll (
    .clk_i, .rst_ni,
    .load_i(park_load), .run_i(state_q == ST_PARK),
    .ival_i(poll_ival), .expire_o(poll_due)
  );

  tdma_byte_sel u_bsel (.word_i(word_q), .idx_i(idx_q), .byte_o(tx_data_o));

  assign beat = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      nxt_q    <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      f_eop_q  <= 1'b0;
      f_sop_q  <= 1'b0;
      f_icpt_q <= 1'b0;
      f_ieop_q <= 1'b0;
      word_q   <= '0;
      idx_q    <= '0;
      first_q  <= 1'b0;
      stop_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (off_p && state_q != ST_IDLE && state_q != ST_PARK) stop_q <= 1'b1;
      if (state_q == ST_IDLE) stop_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (!off_p) begin
          if (start_p) begin
            cur_q   <= first_addr;
            state_q <= ST_PARAM;
          end else if (restart_p) state_q <= ST_PARAM;
        end
        ST_PARAM: if (mem_ack_i) begin
          f_eop_q  <= mem_rdata_i[P_EOP];
          f_sop_q  <= mem_rdata_i[P_SOP];
          f_icpt_q <= mem_rdata_i[P_ICPT];
          f_ieop_q <= mem_rdata_i[P_IEOP];
          cnt_q    <= mem_rdata_i[CW-1:0];
          if (halt)                     state_q <= ST_IDLE;
          else if (mem_rdata_i[P_HOLD]) state_q <= ST_PARK;
          else                          state_q <= ST_NEXT;
        end
        ST_PARK: begin
          if (off_p)                       state_q <= ST_IDLE;
          else if (restart_p || poll_due)  state_q <= ST_PARAM;
        end
        ST_NEXT: if (mem_ack_i) begin
          nxt_q   <= mem_rdata_i[AW-1:0];
          state_q <= halt ? ST_IDLE : ST_BUF;
        end
        ST_BUF: if (mem_ack_i) begin
          ptr_q   <= mem_rdata_i[AW-1:0] & WMASK;
          rem_q   <= cnt_q;
          first_q <= 1'b1;
          if (halt)               state_q <= ST_IDLE;
          else if (cnt_q == '0)   state_q <= ST_DONE;
          else                    state_q <= ST_DATA;
        end
        ST_DATA: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          idx_q   <= '0;
          ptr_q   <= ptr_q + AW'(LANES);
          state_q <= halt ? ST_IDLE : ST_SEND;
        end
        ST_SEND: if (tx_ready_i) begin
          first_q <= 1'b0;
          rem_q   <= rem_q - CW'(1);
          if (halt)                           state_q <= ST_IDLE;
          else if (rem_q == CW'(1))           state_q <= ST_DONE;
          else if (idx_q == IW'(LANES - 1))   state_q <= ST_DATA;
          else                                idx_q   <= idx_q + IW'(1);
        end
        ST_DONE: if (mem_ack_i) begin
          irq_q   <= f_icpt_q || (f_ieop_q && f_eop_q);
          cur_q   <= nxt_q;
          state_q <= halt ? ST_IDLE : ST_PARAM;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o = cur_q;
    unique case (state_q)
      ST_NEXT: mem_addr_o = cur_q + OFS_NEXT;
      ST_BUF:  mem_addr_o = cur_q + OFS_BUF;
      ST_DATA: mem_addr_o = ptr_q;
      ST_DONE: mem_addr_o = cur_q + OFS_DONE;
      default: mem_addr_o = cur_q;
    endcase
  end

  assign mem_req_o   = (state_q == ST_PARAM) || (state_q == ST_NEXT) || (state_q == ST_BUF) ||
                       (state_q == ST_DATA)  || (state_q == ST_DONE);
  assign mem_we_o    = (state_q == ST_DONE);
  assign mem_wdata_o = DONE_WORD;
  assign tx_valid_o  = (state_q == ST_SEND);
  assign tx_sop_o    = first_q && f_sop_q;
  assign tx_eop_o    = (rem_q == CW'(1)) && f_eop_q;
  assign active_o    = (state_q != ST_IDLE);
  assign irq_o       = irq_q;

  // R3: a stalled byte is held unchanged
  a_r3_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !off_p && !stop_q |=>
      tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o));
  // R4: the end-marked byte is the last of its descriptor
  a_r4_eop_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && tx_eop_o |=> !tx_valid_o);
  // R5: the only write is the done flag
  a_r5_done_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o == DONE_WORD && mem_addr_o[1:0] == 2'b00);
  // R6: a held descriptor parks the engine
  a_r6_park_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_load |=> !mem_req_o && !tx_valid_o && active_o);
  // R8: every access is word aligned
  a_r8_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  // R10: off while parked stops at once
  a_r10_off_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_p && state_q == ST_PARK |=> !active_o && !mem_req_o);
endmodule

// File: tb/sim_tdma_tx_dma.sv
`timescale 1ns/1ps
module sim_tdma_tx_dma;
  localparam logic [31:0] HOLD = 32'h8000_0000;
  localparam logic [31:0] EOP  = 32'h4000_0000;
  localparam logic [31:0] SOP  = 32'h2000_0000;
  localparam logic [31:0] ICPT = 32'h1000_0000;
  localparam logic [31:0] IEOP = 32'h0800_0000;
  localparam logic [31:0] DONE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_we, ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, tx_sop, tx_eop, active, irq;
  logic [7:0] tx_data;
  logic rdy_mode = 1'b0;
  logic [1:0] rdy_cnt = '0;

  logic [31:0] mem [0:1023];
  logic [9:0] exp_q [$];
  logic [31:0] rd_addrs [$];
  int watch_t [$];
  logic [31:0] watch = 32'hFFFF_FFFF;
  int cyc = 0, n_tests = 0, n_fail = 0, bytes_rx = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  tdma_tx_dma u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_sop_o(tx_sop), .tx_eop_o(tx_eop), .active_o(active), .irq_o(irq)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  assign tx_ready  = rdy_mode ? (rdy_cnt != 2'd2) : 1'b1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ack <= 1'b0;
    else        ack <= mem_req && !ack;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_cnt <= rdy_cnt + 2'd1;
    if (mem_req && ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: stream scoreboard, read log, irq count
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      bytes_rx++;
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", {22'd0, tx_sop, tx_eop, tx_data}, 32'h0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({tx_sop, tx_eop, tx_data} == e, "R3 R4 stream byte", {22'd0, tx_sop, tx_eop, tx_data}, {22'd0, e});
      end
    end
    if (mem_req && ack && !mem_we) begin
      rd_addrs.push_back(mem_addr);
      if (mem_addr == watch) watch_t.push_back(cyc);
    end
    if (irq) irq_cnt++;
  end

  always @(posedge clk)
    if (cyc == 60000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end

  function automatic logic [7:0] pat(input int base, input int k);
    return 8'((base + 7 * k + 3) & 255);
  endfunction

  task automatic fill_buf(input int base, input int n);
    for (int k = 0; k < n; k++) mem[(base + k) >> 2][8 * ((base + k) % 4) +: 8] = pat(base, k);
  endtask

  task automatic expect_frame(input int base, input int n, input bit s, input bit e);
    for (int k = 0; k < n; k++) exp_q.push_back({s && k == 0, e && k == n - 1, pat(base, k)});
  endtask

  task automatic set_desc(input int a, input logic [31:0] p, input logic [31:0] nx, input logic [31:0] b);
    mem[(a >> 2) + 1] = nx;
    mem[(a >> 2) + 2] = b;
    mem[(a >> 2) + 3] = 32'h0;
    mem[a >> 2]       = p;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_bytes(input int n, input int limit);
    for (int i = 0; i < limit && bytes_rx < n; i++) @(negedge clk);
  endtask

  task automatic check_gaps(input int ival, input string req);
    check(watch_t.size() >= 3, req, watch_t.size(), 3);
    for (int i = 1; i < watch_t.size(); i++)
      check(watch_t[i] - watch_t[i-1] >= ival + 1 && watch_t[i] - watch_t[i-1] <= ival + 4,
            req, watch_t[i] - watch_t[i-1], ival + 3);
  endtask

  function automatic bit seen(input logic [31:0] a);
    foreach (rd_addrs[i]) if (rd_addrs[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    int b0, i0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!tx_valid && !mem_req && !active && !irq, "R1 idle after reset",
          {tx_valid, mem_req, active, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!active && !mem_req, "R1 idle before start", {active, mem_req}, 0);

    // A: single frame, B parked on hold
    fill_buf(32'h400, 6);
    set_desc(32'h100, SOP | EOP | 6, 32'h110, 32'h400);
    set_desc(32'h110, HOLD, 32'h100, 32'h420);
    expect_frame(32'h400, 6, 1, 1);
    watch = 32'h110;
    rd_addrs.delete();
    reg_wr(2'd1, 32'h100);
    reg_wr(2'd0, 32'h1);
    wait_bytes(6, 200);
    repeat (60) @(negedge clk);
    check(rd_addrs[0] == 32'h100, "R2 first read at programmed address", rd_addrs[0], 32'h100);
    check(bytes_rx == 6, "R3 byte count", bytes_rx, 6);
    check(exp_q.size() == 0, "R4 all marked bytes seen", exp_q.size(), 0);
    check(mem[32'h10C >> 2] == DONE, "R5 done flag", mem[32'h10C >> 2], DONE);
    check(seen(32'h110), "R8 follows next pointer", 0, 32'h110);
    check(active && bytes_rx == 6, "R6 parked on hold", {active, bytes_rx[7:0]}, {1'b1, 8'd6});
    check_gaps(7, "R6 default poll spacing");
    check(irq_cnt == 0, "R11 no irq without flags", irq_cnt, 0);

    // B resumes by polling; frame spans B and C with stalls
    fill_buf(32'h440, 5);
    fill_buf(32'h480, 3);
    set_desc(32'h120, EOP | IEOP | 3, 32'h130, 32'h480);
    set_desc(32'h130, HOLD, 32'h100, 32'h0);
    mem[32'h114 >> 2] = 32'h120;
    mem[32'h118 >> 2] = 32'h440;
    rdy_mode = 1'b1;
    expect_frame(32'h440, 5, 1, 0);
    expect_frame(32'h480, 3, 0, 1);
    b0 = bytes_rx;
    rd_addrs.delete();
    mem[32'h110 >> 2] = SOP | IEOP | 5;
    wait_bytes(b0 + 8, 400);
    repeat (40) @(negedge clk);
    check(bytes_rx == b0 + 8, "R3 trimmed two-descriptor frame", bytes_rx - b0, 8);
    check(exp_q.size() == 0, "R4 markers across descriptors", exp_q.size(), 0);
    check(mem[32'h11C >> 2] == DONE && mem[32'h12C >> 2] == DONE, "R5 both done",
          mem[32'h12C >> 2], DONE);
    check(irq_cnt == 1, "R11 irq only on eop-flagged descriptor", irq_cnt, 1);
    check(seen(32'h130), "R8 chain to D", 0, 32'h130);

    // D: zero count, restart with long poll, link back to first
    reg_wr(2'd2, 32'd1000);
    repeat (30) @(negedge clk);
    mem[32'h100 >> 2] = HOLD;
    mem[32'h10C >> 2] = 32'h0;
    mem[32'h134 >> 2] = 32'h100;
    mem[32'h13C >> 2] = 32'h0;
    mem[32'h130 >> 2] = ICPT;
    b0 = bytes_rx; i0 = irq_cnt;
    rd_addrs.delete();
    reg_wr(2'd0, 32'h2);
    repeat (30) @(negedge clk);
    check(rd_addrs.size() > 0 && rd_addrs[0] == 32'h130, "R7 restart re-reads at once",
          rd_addrs.size() > 0 ? rd_addrs[0] : 32'hDEAD, 32'h130);
    check(mem[32'h13C >> 2] == DONE, "R9 zero count completes", mem[32'h13C >> 2], DONE);
    check(bytes_rx == b0, "R9 zero count sends nothing", bytes_rx - b0, 0);
    check(rd_addrs.size() > 3 && rd_addrs[3] == 32'h100, "R8 ring wrap, R9 no buffer read",
          rd_addrs.size() > 3 ? rd_addrs[3] : 32'hDEAD, 32'h100);
    check(irq_cnt == i0 + 1, "R11 irq on completion flag", irq_cnt - i0, 1);

    // poll interval reprogrammed
    watch = 32'h100;
    watch_t.delete();
    reg_wr(2'd2, 32'd20);
    reg_wr(2'd0, 32'h2);
    repeat (100) @(negedge clk);
    check_gaps(20, "R6 programmed poll spacing");

    // off in mid-frame
    fill_buf(32'h500, 40);
    mem[32'h104 >> 2] = 32'h100;
    mem[32'h108 >> 2] = 32'h500;
    mem[32'h10C >> 2] = 32'h0;
    rdy_mode = 1'b0;
    expect_frame(32'h500, 40, 1, 1);
    b0 = bytes_rx;
    mem[32'h100 >> 2] = SOP | EOP | 40;
    wait_bytes(b0 + 5, 100);
    reg_wr(2'd0, 32'h4);
    repeat (20) @(negedge clk);
    check(!active && !tx_valid && !mem_req, "R10 channel stopped", {active, tx_valid, mem_req}, 0);
    check(bytes_rx - b0 >= 5 && bytes_rx - b0 < 40, "R10 frame cut short", bytes_rx - b0, 7);
    check(mem[32'h10C >> 2] == 32'h0, "R10 no done write after off", mem[32'h10C >> 2], 0);
    b0 = bytes_rx;
    repeat (50) @(negedge clk);
    check(bytes_rx == b0 && !active, "R10 stays stopped", bytes_rx - b0, 0);
    exp_q.delete();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule